// File: doc/BRIEF.md
# Cumulative Acknowledgment Scheduler

This block sits on the receive side of a reliable link and decides when an acknowledgment segment should go out. Each in-order segment that has been received but not yet acknowledged adds one to a pending count. While that count is non-zero, an age timer advances on every timebase tick. An acknowledgment is requested as soon as either of two triggers fires:

- the pending count goes past a programmable limit, or
- the age timer reaches a programmable timeout.

The count trigger lets a busy link acknowledge early, without waiting for the timeout.

The request is a single-cycle pulse, `ack_req_o`, one clock after the input cycle that caused it. Only one request is raised per acknowledgment round. When the transmit side reports that an acknowledgment has gone out (`ack_sent_i`), the pending count and the timer are cleared and a new round begins. Building and sending the acknowledgment segment happen elsewhere.

Top module: `ack_sched`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `ack_req_o` is 0 and nothing is pending.
- R2: When a `seg_rx_i` strobe makes the pending count greater than `ack_max_i`, `ack_req_o` pulses in the following cycle, whether or not the timer has expired. With `ack_max_i` = 0, a single segment triggers the request.
- R3: When exactly `ack_max_i` segments are pending and no tick arrives, no request is made.
- R4: A `tick_i` is counted only in cycles where the pending count is already non-zero, so a tick in the same cycle as the first segment is not counted. The tick that brings the counted ticks up to `ack_tout_i` causes a pulse in the following cycle.
- R5: While nothing is pending, ticks do not advance the timer. After an idle stretch, a new segment still needs the full `ack_tout_i` ticks before a timeout request.
- R6: An `ack_sent_i` strobe clears both the pending count and the timer. Afterwards, a full `ack_max_i`+1 segments, or a full `ack_tout_i` ticks, are needed for the next request. In the cycle after an `ack_sent_i` that arrives without a segment, no request is made.
- R7: After a request, no further request is made until `ack_sent_i`, even if more segments and ticks arrive.
- R8: When the count and timeout triggers occur in the same cycle, exactly one pulse is issued. Every pulse lasts one cycle.
- R9: A `seg_rx_i` in the same cycle as `ack_sent_i` counts as one pending segment of the new round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_rx_i | input | 1 | One in-order segment received this cycle |
| ack_sent_i | input | 1 | Acknowledgment transmitted this cycle |
| tick_i | input | 1 | Timebase tick |
| ack_tout_i | input | TMR_W (16) | Timeout in timebase ticks |
| ack_max_i | input | CNT_W (8) | Pending count limit |
| ack_req_o | output | 1 | Acknowledgment request pulse |

## Verification
The properties assume that `ack_max_i` and `ack_tout_i` are stable and known whenever segments are pending. The count-trigger property also assumes that `ack_max_i` is below the saturation value of the pending counter. The stimulus changes the limit and the timeout only in idle cycles after an acknowledgment has cleared the round, and it keeps `ack_max_i` at small values. Strobes are driven as clean single-cycle levels on the falling edge, so the limits are never sampled while they are changing.

// File: rtl/ack_sched_pkg.sv
package ack_sched_pkg;
    // Control state of the request stage
    typedef struct packed {
        logic issued;   // request already raised in this round
        logic req;      // registered request pulse
    } ack_ctl_t;
endpackage

// File: rtl/ack_pend_cnt.sv
module ack_pend_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             seg_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] pend_o,
    output logic             over_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) begin
            // a segment arriving with the clear opens the new round
            pend_d = seg_i ? CNT_W'(1) : '0;
        end else if (seg_i && pend_q != CNT_MAX) begin
            pend_d = pend_q + CNT_W'(1);
        end
        over_o = pend_d > limit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/ack_age_timer.sv
module ack_age_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [TMR_W-1:0] tout_i,
    output logic             expire_o
);
    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    logic [TMR_W-1:0] age_d, age_q;
    logic [TMR_W:0]   age_next;

    always_comb begin
        age_d    = age_q;
        expire_o = 1'b0;
        age_next = {1'b0, age_q} + (TMR_W+1)'(1);
        if (clr_i || !run_i) begin
            age_d = '0;
        end else if (tick_i) begin
            if (age_q != TMR_MAX) age_d = age_q + TMR_W'(1);
            expire_o = age_next >= {1'b0, tout_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) age_q <= '0;
        else         age_q <= age_d;
    end
endmodule

// File: rtl/ack_sched.sv
module ack_sched #(
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             seg_rx_i,
    input  logic             ack_sent_i,
    input  logic             tick_i,
    input  logic [TMR_W-1:0] ack_tout_i,
    input  logic [CNT_W-1:0] ack_max_i,
    output logic             ack_req_o
);
    import ack_sched_pkg::*;

    logic [CNT_W-1:0] pend_q;
    logic             cnt_over;
    logic             age_expire;
    logic             pend_any;
    logic             issued_base;
    logic             fire;
    ack_ctl_t         ctl_d, ctl_q;

    ack_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .seg_i   (seg_rx_i),
        .clr_i   (ack_sent_i),
        .limit_i (ack_max_i),
        .pend_o  (pend_q),
        .over_o  (cnt_over)
    );

    assign pend_any = pend_q != '0;

    ack_age_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (pend_any),
        .clr_i    (ack_sent_i),
        .tick_i   (tick_i),
        .tout_i   (ack_tout_i),
        .expire_o (age_expire)
    );

    always_comb begin
        ctl_d       = ctl_q;
        issued_base = ack_sent_i ? 1'b0 : ctl_q.issued;
        fire        = (cnt_over || age_expire) && !issued_base;
        ctl_d.issued = issued_base || fire;
        ctl_d.req    = fire;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign ack_req_o = ctl_q.req;
endmodule

// File: rtl/ack_sched_chk.sv
module ack_sched_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             seg_rx_i,
    input logic             ack_sent_i,
    input logic [CNT_W-1:0] ack_max_i,
    input logic             ack_req_o,
    input logic [CNT_W-1:0] pend_q,
    input logic             issued_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R2: segment that pushes the count past the limit forces a request
    a_r2_count_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_rx_i && !ack_sent_i && pend_q == ack_max_i && pend_q != CNT_MAX && !issued_q
        |=> ack_req_o);

    // R5: nothing pending and no arrival means no request
    a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_q == '0 && !seg_rx_i |=> !ack_req_o);

    // R6: a clear without a new segment is followed by silence
    a_r6_clear_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_sent_i && !seg_rx_i |=> !ack_req_o);

    // R7: one request per round
    a_r7_one_per_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issued_q && !ack_sent_i |=> !ack_req_o);

    // R8: request pulses are one cycle wide
    a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_req_o && !ack_sent_i |=> !ack_req_o);
endmodule

bind ack_sched ack_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_rx_i   (seg_rx_i),
    .ack_sent_i (ack_sent_i),
    .ack_max_i  (ack_max_i),
    .ack_req_o  (ack_req_o),
    .pend_q     (pend_q),
    .issued_q   (ctl_q.issued)
);

// File: tb/ack_sched_tb.sv
`timescale 1ns/1ps
module ack_sched_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        seg_rx_i = 1'b0;
    logic        ack_sent_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [15:0] ack_tout_i = 16'd5;
    logic [7:0]  ack_max_i = 8'd3;
    logic        ack_req_o;

    always #2.5 clk_i = ~clk_i;

    ack_sched u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .seg_rx_i(seg_rx_i), .ack_sent_i(ack_sent_i),
        .tick_i(tick_i), .ack_tout_i(ack_tout_i), .ack_max_i(ack_max_i), .ack_req_o(ack_req_o)
    );

    typedef struct { int unsigned cyc; string tag; } exp_t;
    exp_t        exp_q[$];
    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          running = 0;
    bit          done = 0;
    string       cur_tag = "R1";

    always @(posedge clk_i) cyc <= cyc + 1;

    // monitor: compares observed pulses with the scoreboard
    always @(negedge clk_i) begin
        if (running) begin
            if (ack_req_o) begin
                n_chk++;
                if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                    void'(exp_q.pop_front());
                end else begin
                    n_err++;
                    $display("FAIL %s: ack_req_o=1 at cycle %0d, expected 0", cur_tag, cyc);
                end
            end else if (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                n_chk++; n_err++;
                $display("FAIL %s: ack_req_o=0 at cycle %0d, expected 1", exp_q[0].tag, cyc);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic step(input bit s, input bit a, input bit t, input bit fire, input string tag);
        @(negedge clk_i);
        seg_rx_i = s; ack_sent_i = a; tick_i = t;
        if (fire) exp_q.push_back('{cyc + 1, tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, "");
    endtask

    task automatic ack();
        step(0, 1, 0, 0, "");
    endtask

    task automatic drain(input string tag);
        idle(3);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL %s: %0d pending expectations, expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    always @(posedge clk_i) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: cycle %0d, expected end before 20000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i);
            n_chk++;
            if (ack_req_o !== 1'b0) begin
                n_err++;
                $display("FAIL R1: ack_req_o=%b in reset, expected 0", ack_req_o);
            end
        end
        @(negedge clk_i); rst_ni = 1'b1;
        running = 1;
        idle(2); drain("R1");

        // R3 then R2: limit 3
        cur_tag = "R3";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "");
        drain("R3");
        cur_tag = "R2";
        step(1, 0, 0, 1, "R2");
        idle(1); ack(); drain("R2");

        // R4: timeout of 5 ticks
        cur_tag = "R4";
        step(1, 0, 1, 0, "");           // tick with first segment is not counted
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "");
        step(0, 0, 1, 1, "R4");
        idle(1); ack(); drain("R4");

        // R5: ticks with nothing pending do not age
        cur_tag = "R5";
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "");
        drain("R5");
        step(1, 0, 0, 0, "");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "");
        step(0, 0, 1, 1, "R5");
        idle(1); ack(); drain("R5");

        // R6: clear restarts both triggers
        cur_tag = "R6";
        step(1, 0, 0, 0, ""); step(1, 0, 0, 0, "");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "");
        ack();
        step(1, 0, 0, 0, "");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "");
        step(0, 0, 1, 1, "R6");
        idle(1); ack(); drain("R6");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "");
        step(1, 0, 0, 1, "R6");
        idle(1); ack(); drain("R6");

        // R7: one request per round
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "");
        step(1, 0, 0, 1, "R7");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "");
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "");
        drain("R7");
        ack(); drain("R7");

        // R8: both triggers in one cycle
        cur_tag = "R8";
        step(1, 0, 0, 0, "");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "");
        step(1, 0, 0, 0, ""); step(1, 0, 0, 0, "");
        step(1, 0, 1, 1, "R8");
        drain("R8");
        ack(); drain("R8");

        // R9: segment with the clear counts as one
        cur_tag = "R9";
        step(1, 0, 0, 0, ""); step(1, 0, 0, 0, "");
        step(1, 1, 0, 0, "");
        step(1, 0, 0, 0, ""); step(1, 0, 0, 0, "");
        step(1, 0, 0, 1, "R9");
        idle(1); ack(); drain("R9");

        // R2 with limit 0, R4 with timeout 1
        cur_tag = "R2";
        ack_max_i = 8'd0;
        idle(1);
        step(1, 0, 0, 1, "R2");
        idle(1); ack(); drain("R2");
        cur_tag = "R4";
        ack_max_i = 8'd10; ack_tout_i = 16'd1;
        idle(1);
        step(1, 0, 0, 0, "");
        step(0, 0, 1, 1, "R4");
        idle(1); ack(); drain("R4");

        done = 1;
        summary();
        $finish;
    end
endmodule